// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block models a single programmable output cell of a sum-of-products logic device. A data sum term feeds a D register or bypasses it. A second sum term, the "E" term, has two possible roles. It can be a load enable on the shared output clock, or it can be the cell's own private clock. Static configuration inputs select the operating mode and two polarities: one for the data term and one for the E term. A shared active-high reset clears the register asynchronously.

A pin-connected cell drives its pin through an inverting buffer, and its own output-enable term controls that buffer. The cell reads the pin back on the input side. When the buffer is off, the pin value comes from outside, so a buried or dynamically disabled cell still gives a usable input. The cell also has true and complement feedback outputs, taken before the output buffer. The buried variant, chosen by parameter, has no pin drive, no output enable and no data polarity. It keeps both feedbacks.

Top module: `pld_out_cell`

## Requirements
- R1: While `rst_term` is 1 the register holds 0 at once, with no clock edge needed. In registered mode this makes `fb_true` 0 and `pin_out` 1.
- R2: Clock-enable mode is `cfg_sync`=1 and `cfg_cks`=0. In this mode, a rising `clk_out` with effective enable (`e_term` XOR `cfg_epol`) equal to 1 loads the polarity-adjusted data into the register.
- R3: In clock-enable mode, a rising `clk_out` with effective enable 0 leaves the register unchanged.
- R4: `cfg_epol`=1 inverts the sense of the E term, so `e_term`=0 enables loading and `e_term`=1 holds.
- R5: The polarity-adjusted data is `d_term` XOR `cfg_dpol`. With `cfg_dpol`=1 the register stores the complement of `d_term`.
- R6: Sum-term-clock mode is `cfg_sync`=1 and `cfg_cks`=1. In this mode the register loads on each rising edge of the effective E signal, and `clk_out` edges have no effect on it.
- R7: Combinational mode is `cfg_sync`=0. In this mode `fb_true` equals the polarity-adjusted data with no clock, and `cfg_cks` has no effect.
- R8: `pin_out` is always the complement of `fb_true`.
- R9: `pin_oe` follows `oe_term`. `pin_rd` equals `pin_out` when `pin_oe`=1 and equals `pin_ext` when `pin_oe`=0.
- R10: `fb_comp` is always the complement of `fb_true`.
- R11: With `BURIED`=1, `pin_oe` stays 0, `cfg_dpol` has no effect on the stored or bypassed data, and `pin_rd` equals `pin_ext`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_out | input | 1 | Shared output clock |
| rst_term | input | 1 | Shared asynchronous reset term, active high |
| d_term | input | 1 | Data sum term |
| e_term | input | 1 | Enable / private clock sum term |
| oe_term | input | 1 | Output-enable term |
| cfg_sync | input | 1 | 1 = registered, 0 = combinational |
| cfg_cks | input | 1 | 1 = sum-term clock, 0 = clock enable |
| cfg_dpol | input | 1 | Data polarity invert |
| cfg_epol | input | 1 | E term polarity invert |
| pin_ext | input | 1 | Value driven on the pin from outside when released |
| pin_out | output | 1 | Inverted value driven toward the pin |
| pin_oe | output | 1 | Pin driver enable |
| pin_rd | output | 1 | Pin value seen by the input-side readback |
| fb_true | output | 1 | True feedback before the buffer |
| fb_comp | output | 1 | Complement feedback |

## Verification
The clocked assertions sample at rising `clk_out`. They assume that the configuration inputs are static in operation and that data, enable and output-enable terms change away from that edge. The bench changes configuration only while reset is held, and drives every other input half a period away from the clock. In sum-term-clock mode the assertions assume `e_term` is a clean single-edge signal. The bench therefore raises and lowers it in separate steps, with data settled beforehand and no glitches.

// File: rtl/pld_out_cell.sv
module pld_out_cell #(
  parameter bit BURIED = 1'b0
) (
  input  logic clk_out,
  input  logic rst_term,
  input  logic d_term,
  input  logic e_term,
  input  logic oe_term,
  input  logic cfg_sync,
  input  logic cfg_cks,
  input  logic cfg_dpol,
  input  logic cfg_epol,
  input  logic pin_ext,
  output logic pin_out,
  output logic pin_oe,
  output logic pin_rd,
  output logic fb_true,
  output logic fb_comp
);

  logic d_adj, e_adj;
  logic q_ce, q_st, q_sel, core;

  assign d_adj = d_term ^ (BURIED ? 1'b0 : cfg_dpol);
  assign e_adj = e_term ^ cfg_epol;

  always_ff @(posedge clk_out or posedge rst_term) begin
    if (rst_term)   q_ce <= 1'b0;
    else if (e_adj) q_ce <= d_adj;
  end

  always_ff @(posedge e_adj or posedge rst_term) begin
    if (rst_term) q_st <= 1'b0;
    else          q_st <= d_adj;
  end

  assign q_sel   = cfg_cks ? q_st : q_ce;
  assign core    = cfg_sync ? q_sel : d_adj;
  assign fb_true = core;
  assign fb_comp = ~core;

  generate
    if (BURIED) begin : g_buried
      assign pin_out = ~core;
      assign pin_oe  = 1'b0;
      assign pin_rd  = pin_ext;
      logic unused_oe;
      assign unused_oe = oe_term;
    end else begin : g_pin
      assign pin_out = ~core;
      assign pin_oe  = oe_term;
      assign pin_rd  = oe_term ? ~core : pin_ext;
    end
  endgenerate

endmodule

module pld_out_cell_chk #(
  parameter bit BURIED = 1'b0
) (
  input logic clk_out,
  input logic rst_term,
  input logic d_term,
  input logic e_term,
  input logic oe_term,
  input logic cfg_sync,
  input logic cfg_cks,
  input logic cfg_dpol,
  input logic cfg_epol,
  input logic pin_ext,
  input logic pin_out,
  input logic pin_oe,
  input logic pin_rd,
  input logic fb_true,
  input logic fb_comp
);

  logic dp;
  assign dp = BURIED ? 1'b0 : cfg_dpol;

  always_ff @(posedge clk_out) begin
    if (rst_term && cfg_sync) AST_RESET_CLEARS: assert (!fb_true && pin_out); // R1
  end

  AST_CE_LOADS: assert property (@(posedge clk_out) disable iff (rst_term)
    (cfg_sync && !cfg_cks && (e_term ^ cfg_epol)) |=> (fb_true == $past(d_term ^ dp))); // R2

  AST_CE_HOLDS: assert property (@(posedge clk_out) disable iff (rst_term)
    (cfg_sync && !cfg_cks && !(e_term ^ cfg_epol)) |=> $stable(fb_true)); // R3

  AST_COMB_FOLLOWS: assert property (@(posedge clk_out) disable iff (rst_term)
    !cfg_sync |-> (pin_out != (d_term ^ dp))); // R7

  AST_PIN_READBACK: assert property (@(posedge clk_out) disable iff (rst_term)
    pin_oe |-> (pin_rd == fb_comp)); // R9

  AST_PIN_RELEASED: assert property (@(posedge clk_out) disable iff (rst_term)
    !pin_oe |-> (pin_rd == pin_ext)); // R9

  AST_BURIED_NO_DRIVE: assert property (@(posedge clk_out) disable iff (rst_term)
    BURIED |-> !pin_oe); // R11

  logic unused_in;
  assign unused_in = oe_term;

endmodule

bind pld_out_cell pld_out_cell_chk #(.BURIED(BURIED)) u_chk (
  .clk_out(clk_out), .rst_term(rst_term), .d_term(d_term), .e_term(e_term),
  .oe_term(oe_term), .cfg_sync(cfg_sync), .cfg_cks(cfg_cks), .cfg_dpol(cfg_dpol),
  .cfg_epol(cfg_epol), .pin_ext(pin_ext), .pin_out(pin_out), .pin_oe(pin_oe),
  .pin_rd(pin_rd), .fb_true(fb_true), .fb_comp(fb_comp)
);

// File: tb/pld_out_cell_bench.sv
module pld_out_cell_bench;
  localparam int CLK_PERIOD = 10;

  logic clk_out = 1'b0, rst_term = 1'b1;
  logic d_term = 0, e_term = 0, oe_term = 0;
  logic cfg_sync = 1, cfg_cks = 0, cfg_dpol = 0, cfg_epol = 0, pin_ext = 0;
  logic pin_out, pin_oe, pin_rd, fb_true, fb_comp;
  logic b_out, b_oe, b_rd, b_true, b_comp;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_out = ~clk_out;

  pld_out_cell #(.BURIED(1'b0)) u_pld_out_cell (
    .clk_out, .rst_term, .d_term, .e_term, .oe_term, .cfg_sync, .cfg_cks,
    .cfg_dpol, .cfg_epol, .pin_ext, .pin_out, .pin_oe, .pin_rd, .fb_true, .fb_comp);

  pld_out_cell #(.BURIED(1'b1)) u_buried (
    .clk_out, .rst_term, .d_term, .e_term, .oe_term, .cfg_sync, .cfg_cks,
    .cfg_dpol, .cfg_epol, .pin_ext, .pin_out(b_out), .pin_oe(b_oe), .pin_rd(b_rd),
    .fb_true(b_true), .fb_comp(b_comp));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_out); #2;
  endtask

  task automatic setup(input logic s, input logic c, input logic dp, input logic ep);
    @(negedge clk_out);
    rst_term = 1; d_term = 0; e_term = 0;
    #1; cfg_sync = s; cfg_cks = c; cfg_dpol = dp; cfg_epol = ep;
    @(negedge clk_out); rst_term = 0;
  endtask

  task automatic t_reset();
    setup(1, 0, 0, 0);
    check("R1 reset fb", fb_true, 0);
    check("R8 reset pin", pin_out, 1);
    check("R10 reset comp", fb_comp, 1);
    @(negedge clk_out); d_term = 1; e_term = 1; tick();
    check("R2 load before async reset", fb_true, 1);
    rst_term = 1; #1;
    check("R1 async clear", fb_true, 0);
    check("R8 pin after clear", pin_out, 1);
    #1 rst_term = 0;
  endtask

  task automatic t_ce();
    setup(1, 0, 0, 0);
    @(negedge clk_out); d_term = 1; e_term = 1; tick();
    check("R2 load one", fb_true, 1);
    check("R10 comp", fb_comp, 0);
    @(negedge clk_out); d_term = 0; e_term = 0; tick();
    check("R3 hold", fb_true, 1);
    tick();
    check("R3 hold again", fb_true, 1);
    @(negedge clk_out); e_term = 1; tick();
    check("R2 load zero", fb_true, 0);
  endtask

  task automatic t_epol();
    setup(1, 0, 0, 1);
    @(negedge clk_out); d_term = 1; e_term = 0; tick();
    check("R4 inverted enable loads", fb_true, 1);
    @(negedge clk_out); d_term = 0; e_term = 1; tick();
    check("R4 inverted enable holds", fb_true, 1);
  endtask

  task automatic t_dpol();
    setup(1, 0, 1, 0);
    @(negedge clk_out); d_term = 0; e_term = 1; tick();
    check("R5 inverted data", fb_true, 1);
    check("R11 buried ignores dpol", b_true, 0);
    @(negedge clk_out); d_term = 1; tick();
    check("R5 inverted data 2", fb_true, 0);
  endtask

  task automatic t_stclk();
    setup(1, 1, 0, 0);
    @(negedge clk_out); d_term = 1; tick(); tick();
    check("R6 clk_out ignored", fb_true, 0);
    @(negedge clk_out); e_term = 1; #1;
    check("R6 e edge loads", fb_true, 1);
    @(negedge clk_out); d_term = 0; tick();
    check("R6 no load without e edge", fb_true, 1);
    @(negedge clk_out); e_term = 0; #1;
    check("R6 falling e no load", fb_true, 1);
    #2 e_term = 1; #1;
    check("R6 second rise loads", fb_true, 0);
    #1 e_term = 0;
  endtask

  task automatic t_comb();
    setup(0, 1, 0, 0);
    @(negedge clk_out); d_term = 1; #1;
    check("R7 comb passes", fb_true, 1);
    check("R8 comb pin", pin_out, 0);
    d_term = 0; #1;
    check("R7 comb follows", fb_true, 0);
    setup(0, 0, 1, 0);
    @(negedge clk_out); d_term = 0; #1;
    check("R7 comb with dpol", fb_true, 1);
    check("R11 buried comb no dpol", b_true, 0);
  endtask

  task automatic t_pin();
    setup(0, 0, 0, 0);
    @(negedge clk_out); d_term = 1; oe_term = 1; pin_ext = 1; #1;
    check("R9 oe follows", pin_oe, 1);
    check("R9 readback driven", pin_rd, 0);
    check("R11 buried no oe", b_oe, 0);
    check("R11 buried reads ext", b_rd, 1);
    oe_term = 0; #1;
    check("R9 oe released", pin_oe, 0);
    check("R9 readback ext 1", pin_rd, 1);
    pin_ext = 0; #1;
    check("R9 readback ext 0", pin_rd, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (2) @(posedge clk_out);
    t_reset();
    t_ce();
    t_epol();
    t_dpol();
    t_stclk();
    t_comb();
    t_pin();
    finish_up();
  end
endmodule